// File: doc/BRIEF.md
# Longest-Length Forwarding Port Selector

This block makes the final forwarding decision for a prefix table that has been split into one partition per output port. Each partition reports, on a vector of length lines, which prefix lengths it matched for the current destination address. The selector looks across all partitions, finds the longest prefix length that any of them matched, and names the partition (and so the output port) that holds it.

The search runs in two steps. First, all port vectors are ORed per length, and the highest set length is located. Second, every port is tested for that single length, and the holding port is encoded. The logic works on the length lines of each port only, never on individual table entries, so its size stays close to that of a small priority encoder. The decision is registered, and it appears one clock after the vectors are presented.

Top module: `lpm_port_select`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `hit`=0, `port_idx`=0, `match_len`=0 and `conflict`=0.
- R2: When no input line is set, `hit` is 0 and `port_idx`, `match_len` and `conflict` are all 0.
- R3: Bit `p*LEN_W + (L-1)` of `len_vec` means that port p matched prefix length L (1..LEN_W). `match_len` is the largest L set in any port, as an unsigned binary value (6 bits for LEN_W=32), and `hit` is 1.
- R4: `port_idx` is the unsigned binary number of a port whose vector holds length `match_len`.
- R5: When several ports hold the largest length, `port_idx` is the lowest of them and `conflict` is 1.
- R6: When exactly one port holds the largest length, `conflict` is 0, whatever shorter lengths other ports hold.
- R7: Outputs reflect `len_vec` as sampled at the previous rising edge, and stay unchanged between edges.
- R8: Length 1 (bit 0 of a port) and length LEN_W (top bit of a port) are each selected correctly on every port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| len_vec | input | NUM_PORTS*LEN_W | Matched-length lines, LEN_W per port, port 0 in the low bits |
| hit | output | 1 | Some port matched some length |
| port_idx | output | max(1,clog2(NUM_PORTS)) | Selected port number |
| match_len | output | clog2(LEN_W+1) | Winning prefix length |
| conflict | output | 1 | More than one port holds the winning length |

## Verification
The bench sweeps every length on every port, alone and with shorter lengths scattered over the other ports. A design that picked the first port with any match, and not the longest length, would fail there. Paired ties at each length catch a design that lets the highest port win or never raises the conflict flag. The extreme lengths 1 and 32 catch off-by-one slips in the length encoding. The all-zero vector and a check taken between edges catch a design that leaks stale values or answers combinationally.

// File: rtl/lpm_sel_pkg.sv
// Package: shared sizing helpers for the longest-length port selector.
// Assumes: port and length counts are positive.
package lpm_sel_pkg;

    // Width of a binary index that can name n items (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Width of a binary value that can hold 0..n.
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lpm_len_union.sv
// Module: ORs the length lines of all ports per length.
// Assumes: port p occupies bits [p*LEN_W +: LEN_W] of the flat input.
module lpm_len_union #(
    parameter int NUM_PORTS = 4,
    parameter int LEN_W     = 32
) (
    input  logic [NUM_PORTS*LEN_W-1:0] vec_in,
    output logic [LEN_W-1:0]           any_len
);

    // Per-length OR across every port slice.
    always_comb begin
        any_len = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            any_len = any_len | vec_in[p*LEN_W +: LEN_W];
        end
    end

endmodule

// File: rtl/lpm_top_len.sv
// Module: locates the highest set length line.
// Assumes: bit i stands for length i+1; outputs a one-hot marker and binary length.
module lpm_top_len #(
    parameter int LEN_W = 32,
    localparam int LW   = lpm_sel_pkg::count_width(LEN_W)
) (
    input  logic [LEN_W-1:0] any_len,
    output logic [LEN_W-1:0] top_mark,
    output logic [LW-1:0]    top_len,
    output logic             found
);

    // Upward scan so the last set bit seen (the longest) wins.
    always_comb begin
        top_mark = '0;
        top_len  = '0;
        found    = 1'b0;
        for (int i = 0; i < LEN_W; i++) begin
            if (any_len[i]) begin
                top_mark    = '0;
                top_mark[i] = 1'b1;
                top_len     = LW'(i + 1);
                found       = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lpm_port_pick.sv
// Module: finds which ports hold the marked length and encodes the lowest one.
// Assumes: top_mark is one-hot or zero.
module lpm_port_pick #(
    parameter int NUM_PORTS = 4,
    parameter int LEN_W     = 32,
    localparam int PW       = lpm_sel_pkg::idx_width(NUM_PORTS)
) (
    input  logic [NUM_PORTS*LEN_W-1:0] vec_in,
    input  logic [LEN_W-1:0]           top_mark,
    output logic [PW-1:0]              port_sel,
    output logic                       multi
);

    logic [NUM_PORTS-1:0] holds;

    // One holder test per port.
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_hold
        assign holds[g] = |(vec_in[g*LEN_W +: LEN_W] & top_mark);
    end

    // Downward scan so the lowest holding port wins; count holders.
    always_comb begin
        int n;
        n        = 0;
        port_sel = '0;
        for (int p = NUM_PORTS - 1; p >= 0; p--) begin
            if (holds[p]) begin
                port_sel = PW'(p);
                n        = n + 1;
            end
        end
        multi = (n > 1);
    end

endmodule

// File: rtl/lpm_port_select.sv
// Module: longest-length forwarding port selector (top).
// Assumes: flat vector, port p in bits [p*LEN_W +: LEN_W], bit i = length i+1.
// One-cycle registered decision; synchronous active-low reset.
module lpm_port_select #(
    parameter int NUM_PORTS = 4,
    parameter int LEN_W     = 32,
    localparam int PW       = lpm_sel_pkg::idx_width(NUM_PORTS),
    localparam int LW       = lpm_sel_pkg::count_width(LEN_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PORTS*LEN_W-1:0] len_vec,
    output logic                       hit,
    output logic [PW-1:0]              port_idx,
    output logic [LW-1:0]              match_len,
    output logic                       conflict
);

    logic [LEN_W-1:0] any_len;
    logic [LEN_W-1:0] top_mark;
    logic [LW-1:0]    top_len;
    logic             found;
    logic [PW-1:0]    port_sel;
    logic             multi;

    lpm_len_union #(.NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W)) u_union (
        .vec_in (len_vec),
        .any_len(any_len)
    );

    lpm_top_len #(.LEN_W(LEN_W)) u_top (
        .any_len (any_len),
        .top_mark(top_mark),
        .top_len (top_len),
        .found   (found)
    );

    lpm_port_pick #(.NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W)) u_pick (
        .vec_in  (len_vec),
        .top_mark(top_mark),
        .port_sel(port_sel),
        .multi   (multi)
    );

    // Register the decision; zeros on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit       <= 1'b0;
            port_idx  <= '0;
            match_len <= '0;
            conflict  <= 1'b0;
        end else begin
            hit       <= found;
            port_idx  <= port_sel;
            match_len <= top_len;
            conflict  <= multi;
        end
    end

endmodule

// File: rtl/lpm_port_select_chk.sv
// Module: property checker for lpm_port_select, attached by bind.
// Assumes: same parameters as the checked instance.
module lpm_port_select_chk #(
    parameter int NUM_PORTS = 4,
    parameter int LEN_W     = 32,
    localparam int PW       = lpm_sel_pkg::idx_width(NUM_PORTS),
    localparam int LW       = lpm_sel_pkg::count_width(LEN_W)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_PORTS*LEN_W-1:0] len_vec,
    input logic                       hit,
    input logic [PW-1:0]              port_idx,
    input logic [LW-1:0]              match_len,
    input logic                       conflict
);

    logic [NUM_PORTS*LEN_W-1:0] vec_q;
    logic [LEN_W-1:0]           union_q;
    logic                       win_bit;

    // Keep the vector the outputs were computed from.
    always_ff @(posedge clk) vec_q <= len_vec;

    // Per-length union of the held vector.
    always_comb begin
        union_q = '0;
        for (int p = 0; p < NUM_PORTS; p++) union_q = union_q | vec_q[p*LEN_W +: LEN_W];
    end

    // Held-vector bit at the reported port and length.
    always_comb begin
        int k;
        k = int'(port_idx) * LEN_W + int'(match_len) - 1;
        win_bit = (k >= 0 && k < NUM_PORTS*LEN_W) ? vec_q[k] : 1'b0;
    end

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (port_idx == '0 && match_len == '0 && !conflict));

    // R3
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (match_len >= LW'(1) && match_len <= LW'(LEN_W)));

    // R3
    no_longer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((union_q >> match_len) == '0));

    // R4
    port_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> win_bit);

    // R5
    conflict_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> hit);

    // R7
    hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (hit == $past(|len_vec)));

endmodule

bind lpm_port_select lpm_port_select_chk #(.NUM_PORTS(NUM_PORTS), .LEN_W(LEN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .len_vec  (len_vec),
    .hit      (hit),
    .port_idx (port_idx),
    .match_len(match_len),
    .conflict (conflict)
);

// File: tb/lpm_port_select_test.sv
// Bench: sweeps every length on every port, with noise, ties and empty input.
module lpm_port_select_test;

    localparam int NP = 4;
    localparam int LW = 32;
    localparam int TOT = NP * LW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [TOT-1:0] len_vec = '0;
    logic           hit;
    logic [1:0]     port_idx;
    logic [5:0]     match_len;
    logic           conflict;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    lpm_port_select #(.NUM_PORTS(NP), .LEN_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .len_vec(len_vec),
        .hit(hit), .port_idx(port_idx), .match_len(match_len), .conflict(conflict)
    );

    // 50 MHz clock.
    always #10 clk = ~clk;

    // Compare one value and log a mismatch.
    task automatic cmp(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected decision from the requirements: longest length, lowest port.
    task automatic model(input logic [TOT-1:0] v, output int eh, output int ep,
                         output int el, output int ec);
        eh = 0; ep = 0; el = 0; ec = 0;
        for (int l = LW; l >= 1; l--) begin
            if (eh == 0) begin
                int cnt;
                cnt = 0;
                for (int p = NP - 1; p >= 0; p--) begin
                    if (v[p*LW + l - 1]) begin
                        cnt++;
                        ep = p;
                    end
                end
                if (cnt > 0) begin
                    eh = 1; el = l; ec = (cnt > 1) ? 1 : 0;
                end
            end
        end
    endtask

    // Drive at a falling edge, check one rising edge later.
    task automatic apply(input logic [TOT-1:0] v, input string req);
        int eh, ep, el, ec;
        @(negedge clk);
        len_vec = v;
        @(negedge clk);
        model(v, eh, ep, el, ec);
        cmp(req, "hit", int'(hit), eh);
        cmp(req, "match_len", int'(match_len), el);
        cmp(req, "port_idx", int'(port_idx), ep);
        cmp(req, "conflict", int'(conflict), ec);
    endtask

    initial begin
        logic [TOT-1:0] v;
        // R1: reset clears outputs even with input present.
        len_vec = '1;
        repeat (3) @(negedge clk);
        cmp("R1", "hit", int'(hit), 0);
        cmp("R1", "match_len", int'(match_len), 0);
        cmp("R1", "port_idx", int'(port_idx), 0);
        cmp("R1", "conflict", int'(conflict), 0);
        rst_n = 1'b1;

        // R2: empty input.
        apply('0, "R2");

        // R3 R4 R6 R8: each length alone on each port, then with shorter noise elsewhere.
        for (int l = 1; l <= LW; l++) begin
            for (int p = 0; p < NP; p++) begin
                v = '0;
                v[p*LW + l - 1] = 1'b1;
                apply(v, (l == 1 || l == LW) ? "R8" : "R3/R4");
                for (int q = 0; q < NP; q++) begin
                    if (q != p) v[q*LW +: LW] = ({LW{1'b1}} >> (LW - l + 1)) & LW'($urandom);
                end
                v[p*LW +: LW] = v[p*LW +: LW] | (({LW{1'b1}} >> (LW - l + 1)) & LW'($urandom));
                apply(v, "R6");
            end
        end

        // R5: ties between every pair of ports at several lengths.
        for (int l = 1; l <= LW; l += 7) begin
            for (int a = 0; a < NP; a++) begin
                for (int b = a + 1; b < NP; b++) begin
                    v = '0;
                    v[a*LW + l - 1] = 1'b1;
                    v[b*LW + l - 1] = 1'b1;
                    apply(v, "R5");
                end
            end
        end
        apply('1, "R5");

        // Mixed random vectors.
        for (int i = 0; i < 200; i++) begin
            v = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
            apply(v, "R3/R4/R5");
        end

        // R7: outputs hold until the next edge.
        apply(TOT'(1) << (2*LW + 9), "R7");
        @(negedge clk);
        len_vec = '0;
        len_vec[LW + 30] = 1'b1;
        #5;
        cmp("R7", "held match_len", int'(match_len), 10);
        cmp("R7", "held port_idx", int'(port_idx), 2);
        @(negedge clk);
        cmp("R7", "next match_len", int'(match_len), 31);
        cmp("R7", "next port_idx", int'(port_idx), 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule